// File: doc/BRIEF.md
# SPI Master Word Engine

This block is a single-channel SPI master that moves one word per transfer. A word is offered on a parallel input with a valid strobe. The engine then drives chip-select, the serial clock and the outgoing data line, and samples the incoming data line. When the word is done it returns the received bits, right-aligned, and raises an end-of-transfer flag. The word length, clock polarity and phase, chip-select polarity, chip-select spacing and divider ratio are all programmable. The engine can also send an optional leading start bit, wait an initial delay before the first word after enable, and keep chip-select asserted between words.

All timing is counted in half periods of the serial clock. Each half period is the divider ratio times the block clock. The divider has two modes: a power-of-two mode and a 12-bit linear mode. The configuration inputs must stay stable while a word is in flight. They are sampled continuously and are not latched at load.

Top module: `spiw_word_master`

## Requirements
- R1: The length field value w gives a word of w+1 bits for w from 3 to 31. Field values 0, 1 and 2 behave as 3, giving 4 bits. A transfer makes exactly 2·B serial clock edges, where B is the word length plus one if the start bit is enabled.
- R2: Bits go out most-significant first. The received word is the last w+1 bits sampled, right-aligned in `rx_word` with zeros above.
- R3: With `cfg_fine_div` low, each serial clock half period lasts 2^`cfg_div` block clock cycles.
- R4: With `cfg_fine_div` high, each half period lasts ({`cfg_div_ext`,`cfg_div`} + 1) block clock cycles.
- R5: With gap code g, the first clock edge comes (2g+1) half periods after chip-select asserts. Chip-select releases (2g+1) half periods after the last edge.
- R6: With `cfg_sb_en` high, one extra bit at level `cfg_sb_lvl` goes out before the word. The bit sampled in that slot is not part of `rx_word`.
- R7: The idle clock level equals `cfg_cpol`. With `cfg_cpha`=0 data is sampled on odd-numbered edges, and with `cfg_cpha`=1 on even-numbered edges. No clock edge occurs while chip-select is inactive.
- R8: `cfg_xfer` code 1 is receive-only: `mosi` stays low. Code 2 is transmit-only: `rx_word` keeps its previous value. Codes 0 and 3 transmit and receive.
- R9: For the first word after `en` rises, chip-select stays inactive and the clock stays idle for 2·D half periods after load. D is 0, 4, 8, 16 for `cfg_init_dly` codes 0 to 3, and 32 for codes 4 to 7. Later words have no delay.
- R10: `eot` drops in the cycle after a word is loaded. It rises in the same cycle that chip-select releases, or at the end of the word when chip-select is held.
- R11: With `cfg_hold_cs` high, chip-select stays active between words. It releases one cycle after `cfg_hold_cs` goes low while idle.
- R12: With `cfg_cs_low` high, `spi_cs` is low while active. With `cfg_cs_low` low, it is high while active.
- R13: After reset, chip-select is inactive, `sclk` equals `cfg_cpol`, and `eot`, `rx_word` and `mosi` are zero. `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the divider reference |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Channel enable; a rising edge arms the initial delay |
| tx_valid | input | 1 | Word offered for transmission |
| tx_word | input | 32 | Word to send, right-aligned |
| tx_ready | output | 1 | Engine idle and able to load a word |
| cfg_len | input | 5 | Word length minus one |
| cfg_cpol | input | 1 | Idle clock level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_cs_low | input | 1 | Chip-select active low when set |
| cfg_hold_cs | input | 1 | Keep chip-select active between words |
| cfg_fine_div | input | 1 | Linear divider mode when set |
| cfg_div | input | 4 | Divider exponent or low divider bits |
| cfg_div_ext | input | 8 | High divider bits in linear mode |
| cfg_cs_gap | input | 2 | Chip-select to clock spacing code |
| cfg_sb_en | input | 1 | Send a leading start bit |
| cfg_sb_lvl | input | 1 | Start-bit level |
| cfg_xfer | input | 2 | Transfer direction code |
| cfg_init_dly | input | 3 | Initial delay code |
| rx_word | output | 32 | Last received word |
| eot | output | 1 | End-of-transfer flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| spi_cs | output | 1 | Chip-select |

## Verification
Two events can fall in adjacent cycles: the end-of-transfer flag setting and the next load clearing it. The bench provokes this by holding `tx_valid` high across a word boundary. It then checks that `eot` is high for exactly one sampled cycle before the second load drops it. A second case pairs the chip-select release decision with held chip-select. Two words are sent with hold set, and the bench counts any chip-select deassertion between them. It then clears hold while idle and expects release one cycle later.

// File: rtl/spiw_pkg.sv
// Package: shared state encoding and direction codes for the SPI word engine.
// Assumes nothing beyond being compiled before the modules that import it.
package spiw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DELAY,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } spiw_state_t;

    localparam logic [1:0] XFER_RX_ONLY = 2'd1;
    localparam logic [1:0] XFER_TX_ONLY = 2'd2;
endpackage

// File: rtl/spiw_divider.sv
// Half-period tick generator. Emits one tick every `ratio` cycles while run
// is high, where ratio is either 2^div or {ext,div}+1.
// Assumes the divider settings stay stable while run is high.
module spiw_divider #(
    parameter int DIV_W = 4,
    parameter int EXT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fine,
    input  logic [DIV_W-1:0] div,
    input  logic [EXT_W-1:0] ext,
    output logic             tick
);
    localparam int POW_W = 2 ** DIV_W;
    localparam int LIN_W = DIV_W + EXT_W + 1;
    localparam int CNT_W = (POW_W > LIN_W) ? POW_W : LIN_W;

    logic [CNT_W-1:0] ratio;
    logic [CNT_W-1:0] cnt;

    // Select the ratio for the chosen granularity.
    always_comb begin
        if (fine) ratio = CNT_W'({ext, div}) + CNT_W'(1);
        else      ratio = CNT_W'(1) << div;
    end

    assign tick = run && (cnt == ratio - CNT_W'(1));

    // Count cycles within one half period; restart whenever stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + CNT_W'(1);
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < ratio));
endmodule

// File: rtl/spiw_shifter.sv
// Transmit and receive shift registers. The transmit word is aligned so its
// top bit (or the start bit) leaves first; received bits enter at the bottom.
// Assumes word_bits is between 4 and DATA_W.
module spiw_shifter #(
    parameter int DATA_W = 32,
    parameter int BIT_W  = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift_en,
    input  logic              sample_en,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [BIT_W-1:0]  word_bits,
    input  logic              sb_en,
    input  logic              sb_lvl,
    input  logic              miso,
    output logic              mosi_bit,
    output logic [DATA_W-1:0] rx_data
);
    localparam int SR_W = DATA_W + 1;

    logic [SR_W-1:0]   tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] mask;
    logic [BIT_W-1:0]  spare;

    assign spare    = BIT_W'(DATA_W) - word_bits;
    assign aligned  = tx_word << spare;
    assign mask     = {DATA_W{1'b1}} >> spare;
    assign mosi_bit = tx_sr[SR_W-1];
    assign rx_data  = rx_sr & mask;

    // Load the outgoing frame or advance it by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_sr <= '0;
        else if (load)     tx_sr <= sb_en ? {sb_lvl, aligned} : {aligned, 1'b0};
        else if (shift_en) tx_sr <= tx_sr << 1;
    end

    // Clear the receive register at load and collect sampled bits.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_sr <= '0;
        else if (load)      rx_sr <= '0;
        else if (sample_en) rx_sr <= {rx_sr[DATA_W-2:0], miso};
    end

    // R2
    load_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && (sample_en || shift_en)));
endmodule

// File: rtl/spiw_word_master.sv
// Single-channel SPI master word engine. Sequences initial delay, chip-select
// lead, 2*B clock edges and chip-select trail, all counted in divider ticks.
// Assumes configuration inputs are stable from load until eot rises.
module spiw_word_master
    import spiw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 4,
    parameter int EXT_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      tx_valid,
    input  logic [DATA_W-1:0]         tx_word,
    output logic                      tx_ready,
    input  logic [$clog2(DATA_W)-1:0] cfg_len,
    input  logic                      cfg_cpol,
    input  logic                      cfg_cpha,
    input  logic                      cfg_cs_low,
    input  logic                      cfg_hold_cs,
    input  logic                      cfg_fine_div,
    input  logic [DIV_W-1:0]          cfg_div,
    input  logic [EXT_W-1:0]          cfg_div_ext,
    input  logic [1:0]                cfg_cs_gap,
    input  logic                      cfg_sb_en,
    input  logic                      cfg_sb_lvl,
    input  logic [1:0]                cfg_xfer,
    input  logic [2:0]                cfg_init_dly,
    output logic [DATA_W-1:0]         rx_word,
    output logic                      eot,
    output logic                      sclk,
    output logic                      mosi,
    input  logic                      miso,
    output logic                      spi_cs
);
    localparam int LEN_W = $clog2(DATA_W);
    localparam int BIT_W = LEN_W + 1;
    localparam int EC_W  = BIT_W + 1;
    localparam int PH_W  = 7;

    spiw_state_t       state;
    logic [PH_W-1:0]   ph;
    logic [EC_W-1:0]   ecnt;
    logic              sclk_t;
    logic              held;
    logic              first_q;
    logic              tick;
    logic              load;
    logic              edge_now;
    logic              shift_en;
    logic              sample_en;
    logic              mosi_bit;
    logic              cs_act;
    logic [LEN_W-1:0]  eff_len;
    logic [BIT_W-1:0]  word_bits;
    logic [BIT_W-1:0]  nbits;
    logic [EC_W-1:0]   edges_last;
    logic [PH_W-1:0]   lead_last;
    logic [PH_W-1:0]   dly_ticks;
    logic [DATA_W-1:0] rx_data;

    assign eff_len    = (cfg_len < LEN_W'(3)) ? LEN_W'(3) : cfg_len;
    assign word_bits  = BIT_W'(eff_len) + BIT_W'(1);
    assign nbits      = word_bits + BIT_W'(cfg_sb_en);
    assign edges_last = {nbits, 1'b0} - EC_W'(1);
    assign lead_last  = PH_W'({cfg_cs_gap, 1'b0});

    // Map the delay code to a half-period count.
    always_comb begin
        case (cfg_init_dly)
            3'd0:    dly_ticks = PH_W'(0);
            3'd1:    dly_ticks = PH_W'(8);
            3'd2:    dly_ticks = PH_W'(16);
            3'd3:    dly_ticks = PH_W'(32);
            default: dly_ticks = PH_W'(64);
        endcase
    end

    assign tx_ready  = (state == ST_IDLE);
    assign load      = tx_ready && en && tx_valid;
    assign edge_now  = tick && ((state == ST_SHIFT) ||
                                ((state == ST_LEAD) && (ph == lead_last)));
    assign sample_en = edge_now && (cfg_cpha ? ecnt[0] : !ecnt[0]);
    assign shift_en  = edge_now && (cfg_cpha ? (!ecnt[0] && (ecnt != '0)) : ecnt[0]);
    assign cs_act    = held || (state == ST_LEAD) || (state == ST_SHIFT) ||
                       (state == ST_TRAIL);
    assign spi_cs    = cs_act ^ cfg_cs_low;
    assign sclk      = cfg_cpol ^ sclk_t;
    assign mosi      = ((state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_TRAIL)) &&
                       (cfg_xfer != XFER_RX_ONLY) && mosi_bit;

    spiw_divider #(.DIV_W(DIV_W), .EXT_W(EXT_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state != ST_IDLE),
        .fine (cfg_fine_div),
        .div  (cfg_div),
        .ext  (cfg_div_ext),
        .tick (tick)
    );

    spiw_shifter #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift_en (shift_en),
        .sample_en(sample_en),
        .tx_word  (tx_word),
        .word_bits(word_bits),
        .sb_en    (cfg_sb_en),
        .sb_lvl   (cfg_sb_lvl),
        .miso     (miso),
        .mosi_bit (mosi_bit),
        .rx_data  (rx_data)
    );

    // Track whether the next load is the first since enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) first_q <= 1'b1;
        else if (load)     first_q <= 1'b0;
    end

    // Count clock edges and toggle the serial clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            ecnt   <= '0;
            sclk_t <= 1'b0;
        end else if (edge_now) begin
            ecnt   <= ecnt + EC_W'(1);
            sclk_t <= ~sclk_t;
        end
    end

    // Main sequencer: delay, lead, shift and trail phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            ph      <= '0;
            eot     <= 1'b0;
            held    <= 1'b0;
            rx_word <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (load) begin
                        ph    <= '0;
                        eot   <= 1'b0;
                        held  <= 1'b0;
                        state <= (first_q && (dly_ticks != '0)) ? ST_DELAY : ST_LEAD;
                    end else if (!cfg_hold_cs || !en) begin
                        held <= 1'b0;
                    end
                end
                ST_DELAY: if (tick) begin
                    if (ph == dly_ticks - PH_W'(1)) begin
                        ph    <= '0;
                        state <= ST_LEAD;
                    end else ph <= ph + PH_W'(1);
                end
                ST_LEAD: if (tick) begin
                    if (ph == lead_last) begin
                        ph    <= '0;
                        state <= ST_SHIFT;
                    end else ph <= ph + PH_W'(1);
                end
                ST_SHIFT: if (edge_now && (ecnt == edges_last)) begin
                    ph    <= '0;
                    state <= ST_TRAIL;
                end
                ST_TRAIL: if (tick) begin
                    if (ph == lead_last) begin
                        state <= ST_IDLE;
                        eot   <= 1'b1;
                        held  <= cfg_hold_cs && en;
                        if (cfg_xfer != XFER_TX_ONLY) rx_word <= rx_data;
                    end else ph <= ph + PH_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7
    idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (sclk == cfg_cpol));
    // R9
    delay_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY) |-> (!cs_act && (sclk == cfg_cpol)));
    // R10
    eot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !eot);
    // R10
    release_eot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_act) |-> eot);
    // R1
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (ecnt <= edges_last));
endmodule

// File: tb/sim_spiw_word_master.sv
module sim_spiw_word_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        tx_valid = 1'b0;
    logic [31:0] tx_word = '0;
    logic        tx_ready;
    logic [4:0]  cfg_len = 5'd7;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_cs_low = 1'b1, cfg_hold_cs = 1'b0;
    logic        cfg_fine_div = 1'b0, cfg_sb_en = 1'b0, cfg_sb_lvl = 1'b0;
    logic [3:0]  cfg_div = 4'd0;
    logic [7:0]  cfg_div_ext = 8'd0;
    logic [1:0]  cfg_cs_gap = 2'd0, cfg_xfer = 2'd0;
    logic [2:0]  cfg_init_dly = 3'd0;
    logic [31:0] rx_word;
    logic        eot, sclk, mosi, spi_cs;
    logic        miso_r = 1'b0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spiw_word_master u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .tx_valid(tx_valid), .tx_word(tx_word),
        .tx_ready(tx_ready), .cfg_len(cfg_len), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_cs_low(cfg_cs_low), .cfg_hold_cs(cfg_hold_cs), .cfg_fine_div(cfg_fine_div),
        .cfg_div(cfg_div), .cfg_div_ext(cfg_div_ext), .cfg_cs_gap(cfg_cs_gap),
        .cfg_sb_en(cfg_sb_en), .cfg_sb_lvl(cfg_sb_lvl), .cfg_xfer(cfg_xfer),
        .cfg_init_dly(cfg_init_dly), .rx_word(rx_word), .eot(eot), .sclk(sclk),
        .mosi(mosi), .miso(miso_r), .spi_cs(spi_cs)
    );

    // Slave model and timing monitor
    logic        mon_clr = 1'b0;
    logic [63:0] mpat = '0;
    logic [63:0] cap = '0;
    int          nb = 8;
    int          ecount = 0, bad = 0, cs_drops = 0;
    int          t_cs_on = -1, t_cs_off = -1, t_first = -1, t_last = -1, t_eot = -1;
    logic        prev_cs = 1'b0, prev_sclk = 1'b0, prev_eot = 1'b0;

    always @(negedge clk) begin
        logic csa;
        int   k;
        csa = cfg_cs_low ? !spi_cs : spi_cs;
        if (mon_clr) begin
            ecount = 0; bad = 0; cs_drops = 0; cap = '0;
            t_cs_on = -1; t_cs_off = -1; t_first = -1; t_last = -1; t_eot = -1;
            miso_r = cfg_cpha ? 1'b0 : mpat[nb-1];
        end else if (rst_n) begin
            if (csa && !prev_cs) t_cs_on = cyc;
            if (!csa && prev_cs) begin t_cs_off = cyc; cs_drops++; end
            if (eot && !prev_eot) t_eot = cyc;
            if (sclk != prev_sclk) begin
                ecount++;
                if (!csa) bad++;
                if (ecount == 1) t_first = cyc;
                t_last = cyc;
                if (ecount[0] != cfg_cpha) cap = {cap[62:0], mosi};
                else begin
                    k = cfg_cpha ? (ecount - 1) / 2 : ecount / 2;
                    miso_r = (k < nb) ? mpat[nb-1-k] : 1'b0;
                end
            end
            if (!csa && (sclk != cfg_cpol)) bad++;
        end
        prev_cs = csa; prev_sclk = sclk; prev_eot = eot;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Runs one word and checks data, edge count and timing.
    task automatic run_word(input logic [31:0] w, input logic [63:0] pat, input string dtag,
                            input bit timing, input int ratio, input int dly);
        int L, t_load, gap, waited;
        logic [63:0] mskl, exp_cap, exp_rx;
        L = ((cfg_len < 3) ? 3 : int'(cfg_len)) + 1;
        nb = L + int'(cfg_sb_en);
        mpat = pat;
        mskl = (64'd1 << L) - 64'd1;
        exp_cap = (cfg_xfer == 2'd1) ? 64'd0 :
                  ((64'(w) & mskl) | (cfg_sb_en ? (64'(cfg_sb_lvl) << L) : 64'd0));
        exp_rx = (cfg_xfer == 2'd2) ? 64'(rx_word) : (pat & mskl);
        gap = (2 * int'(cfg_cs_gap) + 1) * ratio;
        waited = 0;
        while (!tx_ready && waited < 20000) begin @(negedge clk); waited++; end
        mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
        tx_word = w; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        t_load = cyc;
        chk(eot == 1'b0, "R10 eot low after load", eot, 0);
        waited = 0;
        while (!eot && waited < 20000) begin @(negedge clk); waited++; end
        @(negedge clk);
        chk(eot == 1'b1, "R10 eot set at end", eot, 1);
        chk(ecount == 2 * nb, "R1 edge count", ecount, 2 * nb);
        chk((cap & ((64'd1 << nb) - 64'd1)) == exp_cap, dtag, cap, exp_cap);
        chk(64'(rx_word) == exp_rx, "R2 received word", rx_word, exp_rx);
        chk(bad == 0, "R7 clock activity with chip-select inactive", bad, 0);
        if (timing) begin
            chk(t_cs_on - t_load == dly, "R9 load to chip-select", t_cs_on - t_load, dly);
            chk(t_first - t_cs_on == gap, "R5 lead gap", t_first - t_cs_on, gap);
            chk(t_last - t_first == (2 * nb - 1) * ratio, "R3/R4 half period",
                t_last - t_first, (2 * nb - 1) * ratio);
            chk(t_cs_off - t_last == gap, "R5 trail gap", t_cs_off - t_last, gap);
            chk(t_eot == t_cs_off, "R10 eot with release", t_eot, t_cs_off);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(spi_cs == 1'b1, "R13 cs idle", spi_cs, 1);
        chk(sclk == cfg_cpol, "R13 sclk idle", sclk, cfg_cpol);
        chk(eot == 1'b0 && mosi == 1'b0, "R13 eot/mosi", {eot, mosi}, 0);
        chk(rx_word == 32'd0, "R13 rx_word", rx_word, 0);
        chk(tx_ready == 1'b1, "R13 tx_ready", tx_ready, 1);
    endtask

    task automatic t_basic();
        cfg_len = 5'd7; cfg_cpol = 0; cfg_cpha = 0; cfg_div = 0; cfg_cs_gap = 0;
        run_word(32'hA5, 64'h3C, "R2 mode0 mosi bits", 1'b1, 1, 0);
        cfg_len = 5'd15;
        run_word(32'h1234_8001, 64'hBEEF, "R1 16-bit mosi bits", 1'b1, 1, 0);
    endtask

    task automatic t_pow2();
        cfg_len = 5'd11; cfg_cpol = 1; cfg_cpha = 1; cfg_div = 4'd2; cfg_cs_gap = 2'd2;
        run_word(32'hC3A, 64'h5A3, "R7 cpol1 cpha1 mosi bits", 1'b1, 4, 0);
        @(negedge clk);
        chk(sclk == 1'b1, "R7 idle high", sclk, 1);
        cfg_cpol = 0; cfg_cpha = 1; cfg_div = 4'd1; cfg_cs_gap = 2'd3;
        run_word(32'h9F1, 64'h00F, "R7 cpol0 cpha1 mosi bits", 1'b1, 2, 0);
    endtask

    task automatic t_linear();
        cfg_fine_div = 1; cfg_div_ext = 8'd1; cfg_div = 4'd2; cfg_cs_gap = 0;
        cfg_cpol = 0; cfg_cpha = 0; cfg_len = 5'd3;
        run_word(32'h9, 64'h6, "R4 linear 19 mosi bits", 1'b1, 19, 0);
        cfg_div_ext = 8'd0; cfg_div = 4'd2;
        run_word(32'h6, 64'hD, "R4 linear 3 mosi bits", 1'b1, 3, 0);
        cfg_fine_div = 0; cfg_div = 0;
    endtask

    task automatic t_startbit();
        cfg_len = 5'd31; cfg_sb_en = 1; cfg_sb_lvl = 1; cfg_cpha = 0;
        run_word(32'h8000_0001, 64'h0_7654_3210, "R6 start bit one, 32-bit", 1'b1, 1, 0);
        cfg_len = 5'd4; cfg_sb_lvl = 0;
        run_word(32'h1F, 64'h3F, "R6 start bit zero", 1'b1, 1, 0);
        cfg_sb_en = 0;
    endtask

    task automatic t_reserved_len();
        cfg_len = 5'd1;
        run_word(32'hFFFF_FFFB, 64'h5, "R1 reserved length as 4", 1'b1, 1, 0);
    endtask

    task automatic t_modes();
        cfg_len = 5'd7; cfg_xfer = 2'd1;
        run_word(32'hFF, 64'h81, "R8 receive-only mosi low", 1'b0, 1, 0);
        cfg_xfer = 2'd2;
        run_word(32'h42, 64'h7E, "R8 transmit-only", 1'b0, 1, 0);
        chk(rx_word == 32'h81, "R8 rx kept in transmit-only", rx_word, 32'h81);
        cfg_xfer = 2'd3;
        run_word(32'h3D, 64'hC2, "R8 code 3 as full duplex", 1'b0, 1, 0);
        cfg_xfer = 2'd0;
    endtask

    task automatic t_delay();
        en = 0; @(negedge clk); en = 1;
        cfg_init_dly = 3'd2; cfg_div = 4'd1; cfg_len = 5'd7;
        run_word(32'h5C, 64'hA3, "R9 first word after enable", 1'b1, 2, 32);
        run_word(32'h11, 64'h22, "R9 later word", 1'b1, 2, 0);
        cfg_init_dly = 3'd0; cfg_div = 0;
    endtask

    task automatic t_hold();
        cfg_hold_cs = 1;
        run_word(32'h71, 64'h18, "R11 held word one", 1'b0, 1, 0);
        chk(spi_cs == 1'b0, "R11 cs held after word", spi_cs, 0);
        run_word(32'h2E, 64'hE7, "R11 held word two", 1'b0, 1, 0);
        chk(cs_drops == 0, "R11 no release between words", cs_drops, 0);
        cfg_hold_cs = 0;
        @(negedge clk); @(negedge clk);
        chk(spi_cs == 1'b1, "R11 release after hold cleared", spi_cs, 1);
    endtask

    task automatic t_cspol();
        cfg_cs_low = 0;
        @(negedge clk);
        chk(spi_cs == 1'b0, "R12 active-high idle level", spi_cs, 0);
        run_word(32'h96, 64'h69, "R12 active-high word", 1'b1, 1, 0);
        cfg_cs_low = 1;
    endtask

    task automatic t_back_to_back();
        int waited;
        waited = 0;
        tx_word = 32'h33; tx_valid = 1'b1;
        @(negedge clk);
        while (eot && waited < 100) begin @(negedge clk); waited++; end
        while (!eot && waited < 20000) begin @(negedge clk); waited++; end
        chk(eot == 1'b1, "R10 first eot", eot, 1);
        @(negedge clk);
        chk(eot == 1'b0 && tx_ready == 1'b0, "R10 eot cleared by next load", eot, 0);
        tx_valid = 1'b0;
        while (!eot && waited < 40000) begin @(negedge clk); waited++; end
        chk(eot == 1'b1, "R10 second eot", eot, 1);
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        en = 1'b1;
        t_basic();
        t_pow2();
        t_linear();
        t_startbit();
        t_reserved_len();
        t_modes();
        t_delay();
        t_hold();
        t_cspol();
        t_back_to_back();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule